// File: doc/BRIEF.md
# Dual-Direction Bit Rate Generator

This block produces the transmit and receive bit-rate timing for one serial channel. Each direction has its own clock-source selector and its own 8-bit period divider. The source can be one of five prescaled versions of the system clock, an external clock pin, or, for transmit only, the receive bit-rate strobe. Each direction drives a one-cycle bit-rate enable strobe, which a serializer uses as its clock enable. It also drives a square-wave bit clock that toggles on every strobe, for observation.

Configuration uses a plain register-write port. There is one option register and one period register per direction. There is no data stream through the block, so every pin is a plain control or status pin and none uses a valid/ready handshake. The external clock pins are asynchronous. They are synchronized inside the block, and only their rising edges count as source ticks.

Top module: `dual_bitrate_gen`

## Requirements
- R1: A write takes effect when `cfg_we` is high at a rising clock edge. Address 0 is the transmit option register (source code in bits 2:0). Address 1 is the transmit period. Address 2 is the receive option register (bits 2:0). Address 3 is the receive period.
- R2: Source codes 0 to 4 select prescaled ticks with periods of 8, 32, 128, 512 and 2048 system cycles. All five come from one free-running counter.
- R3: A period value P from 1 to 255 gives one enable strobe for every P source ticks. In steady state the strobe interval is the source period times P.
- R4: A period value of 0 behaves exactly like 1.
- R5: Receive source code 5 selects the receive clock pin. Each rising edge of the pin, after a two-flop synchronizer, is one source tick.
- R6: Transmit source code 5 selects the transmit clock pin, with the same synchronization. Transmit source code 6 selects the receive enable strobe as the transmit source.
- R7: Unused source codes (transmit 7; receive 6 and 7) select source 0, the divide-by-8 tick.
- R8: Each enable strobe lasts one cycle. The bit clock of that direction changes level exactly in the cycles where its strobe is high.
- R9: Any write to one of a direction's two registers restarts that direction's divide count from zero and suppresses its strobe in the following cycle. The other direction is unaffected.
- R10: Synchronous reset selects source 0 with period 1 for both directions, clears all counters, and drives both strobes and both bit clocks low.
- R11: With an effective period of 1, every source tick produces a strobe in the next cycle (1x pass-through).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| tx_ext_clk | input | 1 | Asynchronous external transmit clock |
| rx_ext_clk | input | 1 | Asynchronous external receive clock |
| tx_bit_en | output | 1 | Transmit one-cycle bit-rate strobe |
| rx_bit_en | output | 1 | Receive one-cycle bit-rate strobe |
| tx_bclk | output | 1 | Transmit observation bit clock |
| rx_bclk | output | 1 | Receive observation bit clock |

## Verification
The assertions check these every cycle:
- the divide count stays below the effective period;
- a strobe follows only a source tick;
- a period of 1 passes each tick straight through;
- a reload silences the next cycle;
- the bit clock changes only with a strobe;
- a synchronized pin edge never produces two ticks in a row.

Only the bench scenarios can show that each source code yields the right strobe interval and that period 0 acts as 1. They also show that unused codes fall back to divide-by-8, that transmit can be slaved to the receive strobe, and that a rewrite in mid-count visibly delays the next strobe.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int SRC_W      = 3;
  localparam int DIV_W      = 8;
  localparam int NUM_PRE    = 5;
  localparam int PRE_SHIFT0 = 3;
  localparam int PRE_STEP   = 2;

  typedef enum logic [1:0] {
    CFG_TX_OPT = 2'd0,
    CFG_TX_PER = 2'd1,
    CFG_RX_OPT = 2'd2,
    CFG_RX_PER = 2'd3
  } cfg_addr_e;

  localparam logic [SRC_W-1:0] SRC_PIN   = 3'd5;
  localparam logic [SRC_W-1:0] SRC_RXBIT = 3'd6;
endpackage

// File: rtl/brg_prescale.sv
module brg_prescale #(
  parameter int NUM    = 5,
  parameter int SHIFT0 = 3,
  parameter int STEP   = 2
) (
  input  logic           clk,
  input  logic           rst,
  output logic [NUM-1:0] tick
);
  localparam int W = SHIFT0 + STEP * (NUM - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  for (genvar k = 0; k < NUM; k++) begin : g_tap
    localparam int HI = SHIFT0 + STEP * k;
    assign tick[k] = &cnt[HI-1:0];
  end

  AST_PRE_GAP: assert property (@(posedge clk) disable iff (rst)
    tick[0] |=> !tick[0]); // R2
endmodule

// File: rtl/brg_edge_sync.sv
module brg_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic tick
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[1:0], pin};
  end

  assign tick = sh[1] & ~sh[2];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R5
endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] period,
  output logic             bit_en,
  output logic             bclk
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] p_eff;
  logic             last;

  assign p_eff = (period == '0) ? DIV_W'(1) : period;
  assign last  = (cnt >= p_eff - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      bit_en <= 1'b0;
      bclk   <= 1'b0;
    end else if (reload) begin
      cnt    <= '0;
      bit_en <= 1'b0;
    end else if (src_tick) begin
      if (last) begin
        cnt    <= '0;
        bit_en <= 1'b1;
        bclk   <= ~bclk;
      end else begin
        cnt    <= cnt + 1'b1;
        bit_en <= 1'b0;
      end
    end else begin
      bit_en <= 1'b0;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < p_eff); // R4
  AST_EN_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    bit_en |-> $past(src_tick)); // R3
  AST_PASS_1X: assert property (@(posedge clk) disable iff (rst)
    (src_tick && !reload && p_eff == DIV_W'(1)) |=> bit_en); // R11
  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    reload |=> !bit_en); // R9
  AST_BCLK_WITH_EN: assert property (@(posedge clk) disable iff (rst)
    (bclk != $past(bclk)) |-> bit_en); // R8
endmodule

// File: rtl/dual_bitrate_gen.sv
module dual_bitrate_gen
  import brg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       tx_ext_clk,
  input  logic       rx_ext_clk,
  output logic       tx_bit_en,
  output logic       rx_bit_en,
  output logic       tx_bclk,
  output logic       rx_bclk
);
  logic [SRC_W-1:0] tx_src, rx_src;
  logic [DIV_W-1:0] tx_per, rx_per;
  logic [NUM_PRE-1:0] pre_tick;
  logic tx_pin_tick, rx_pin_tick;
  logic tx_tick, rx_tick;
  logic tx_reload, rx_reload;

  assign tx_reload = cfg_we && (cfg_addr == CFG_TX_OPT || cfg_addr == CFG_TX_PER);
  assign rx_reload = cfg_we && (cfg_addr == CFG_RX_OPT || cfg_addr == CFG_RX_PER);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_src <= '0;
      rx_src <= '0;
      tx_per <= DIV_W'(1);
      rx_per <= DIV_W'(1);
    end else if (cfg_we) begin
      case (cfg_addr)
        CFG_TX_OPT: tx_src <= cfg_wdata[SRC_W-1:0];
        CFG_TX_PER: tx_per <= cfg_wdata;
        CFG_RX_OPT: rx_src <= cfg_wdata[SRC_W-1:0];
        default:    rx_per <= cfg_wdata;
      endcase
    end
  end

  brg_prescale #(.NUM(NUM_PRE), .SHIFT0(PRE_SHIFT0), .STEP(PRE_STEP)) u_pre (
    .clk(clk), .rst(rst), .tick(pre_tick)
  );

  brg_edge_sync u_tx_sync (.clk(clk), .rst(rst), .pin(tx_ext_clk), .tick(tx_pin_tick));
  brg_edge_sync u_rx_sync (.clk(clk), .rst(rst), .pin(rx_ext_clk), .tick(rx_pin_tick));

  always_comb begin
    if (rx_src < SRC_W'(NUM_PRE)) rx_tick = pre_tick[rx_src];
    else if (rx_src == SRC_PIN)   rx_tick = rx_pin_tick;
    else                          rx_tick = pre_tick[0];
  end

  always_comb begin
    if (tx_src < SRC_W'(NUM_PRE))   tx_tick = pre_tick[tx_src];
    else if (tx_src == SRC_PIN)     tx_tick = tx_pin_tick;
    else if (tx_src == SRC_RXBIT)   tx_tick = rx_bit_en;
    else                            tx_tick = pre_tick[0];
  end

  brg_divider #(.DIV_W(DIV_W)) u_rx_div (
    .clk(clk), .rst(rst), .reload(rx_reload), .src_tick(rx_tick),
    .period(rx_per), .bit_en(rx_bit_en), .bclk(rx_bclk)
  );

  brg_divider #(.DIV_W(DIV_W)) u_tx_div (
    .clk(clk), .rst(rst), .reload(tx_reload), .src_tick(tx_tick),
    .period(tx_per), .bit_en(tx_bit_en), .bclk(tx_bclk)
  );

  AST_TX_SLAVE: assert property (@(posedge clk) disable iff (rst)
    (tx_src == SRC_RXBIT && rx_bit_en && !tx_reload && tx_per == DIV_W'(1)) |=> tx_bit_en); // R6
  AST_RX_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    (tx_reload && !rx_reload) |=> $stable(rx_src) && $stable(rx_per)); // R9
endmodule

// File: tb/tb_dual_bitrate_gen.sv
module tb_dual_bitrate_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic tx_ext_clk = 1'b0;
  logic rx_ext_clk = 1'b0;
  logic tx_bit_en, rx_bit_en, tx_bclk, rx_bclk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_bitrate_gen dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tx_ext_clk(tx_ext_clk), .rx_ext_clk(rx_ext_clk),
    .tx_bit_en(tx_bit_en), .rx_bit_en(rx_bit_en), .tx_bclk(tx_bclk), .rx_bclk(rx_bclk)
  );

  // External pins: transmit pin period 10 cycles, receive pin period 6 cycles
  initial forever begin
    repeat (5) @(negedge clk);
    tx_ext_clk = ~tx_ext_clk;
  end
  initial forever begin
    repeat (3) @(negedge clk);
    rx_ext_clk = ~rx_ext_clk;
  end

  typedef struct packed {
    logic        rx;
    logic [2:0]  src;
    logic [7:0]  per;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 8'd1,   16'd8},     // R2 R11
    '{1'b0, 3'd1, 8'd2,   16'd64},    // R2 R3
    '{1'b0, 3'd2, 8'd1,   16'd128},   // R2
    '{1'b0, 3'd3, 8'd0,   16'd512},   // R4
    '{1'b0, 3'd4, 8'd1,   16'd2048},  // R2
    '{1'b0, 3'd0, 8'd255, 16'd2040},  // R3
    '{1'b0, 3'd5, 8'd1,   16'd10},    // R6
    '{1'b0, 3'd5, 8'd4,   16'd40},    // R6 R3
    '{1'b1, 3'd5, 8'd1,   16'd6},     // R5
    '{1'b1, 3'd5, 8'd3,   16'd18},    // R5 R1
    '{1'b1, 3'd0, 8'd3,   16'd24},    // R1
    '{1'b0, 3'd6, 8'd2,   16'd48},    // R6
    '{1'b0, 3'd7, 8'd1,   16'd8},     // R7
    '{1'b1, 3'd6, 8'd1,   16'd8},     // R7
    '{1'b1, 3'd1, 8'd1,   16'd32}     // R2
  };

  task automatic check(input bit ok, input string rq, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic strobe(input bit rx);
    return rx ? rx_bit_en : tx_bit_en;
  endfunction

  function automatic logic bck(input bit rx);
    return rx ? rx_bclk : tx_bclk;
  endfunction

  task automatic wait_strobe(input bit rx, output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!strobe(rx) && waited < 10000);
  endtask

  // Interval between two consecutive strobes; also reports bit clock toggling
  task automatic measure(input bit rx, output int iv, output bit toggled);
    int w;
    logic b0;
    wait_strobe(rx, w);
    b0 = bck(rx);
    wait_strobe(rx, iv);
    toggled = (bck(rx) != b0);
  endtask

  initial begin
    int iv;
    bit tg;
    int w;
    repeat (3) @(negedge clk);
    // R10: outputs low in reset
    check(!tx_bit_en && !rx_bit_en && !tx_bclk && !rx_bclk, "R10 reset outputs", int'({tx_bit_en, rx_bit_en, tx_bclk, rx_bclk}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!tx_bclk && !rx_bclk, "R10 bclk after reset", int'({tx_bclk, rx_bclk}), 0);
    measure(1'b0, iv, tg);
    check(iv == 8, "R10 default tx interval", iv, 8);
    measure(1'b1, iv, tg);
    check(iv == 8, "R10 default rx interval", iv, 8);
    check(tg, "R8 rx bclk toggles", int'(tg), 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      wr(v.rx ? 2'd2 : 2'd0, {5'd0, v.src});
      wr(v.rx ? 2'd3 : 2'd1, v.per);
      measure(v.rx, iv, tg);
      check(iv == int'(v.exp), $sformatf("R1/R3 vector %0d interval", i), iv, int'(v.exp));
      check(tg, $sformatf("R8 vector %0d bclk toggle", i), int'(tg), 1);
    end

    // R8: strobe is a single cycle
    wr(2'd0, 8'd0); wr(2'd1, 8'd2);
    wait_strobe(1'b0, w);
    @(negedge clk);
    check(!tx_bit_en, "R8 strobe one cycle", int'(tx_bit_en), 0);

    // R9: mid-count rewrite restarts the count (pin source, 10-cycle ticks, period 5)
    wr(2'd0, 8'd5); wr(2'd1, 8'd5);
    measure(1'b0, iv, tg);
    check(iv == 50, "R9 baseline interval", iv, 50);
    repeat (19) @(negedge clk);
    wr(2'd1, 8'd5);
    wait_strobe(1'b0, w);
    iv = w + 21;
    check(iv > 55, "R9 reload delays strobe", iv, 70);

    // R9: a transmit write leaves the receive interval untouched
    wr(2'd2, 8'd0); wr(2'd3, 8'd2);
    measure(1'b1, iv, tg);
    check(iv == 16, "R9 rx before tx write", iv, 16);
    wr(2'd1, 8'd3);
    measure(1'b1, iv, tg);
    check(iv == 16, "R9 rx unaffected by tx write", iv, 16);

    // R10: reset restores defaults
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(!tx_bclk && !rx_bclk && !tx_bit_en, "R10 re-reset outputs", int'({tx_bclk, rx_bclk, tx_bit_en}), 0);
    rst = 1'b0;
    measure(1'b0, iv, tg);
    check(iv == 8, "R10 tx default after re-reset", iv, 8);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule